// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block chooses which of five interrupt sources a small 8-bit core services next. The sources are, in fixed polling order: external 0, timer 0, external 1, timer 1 and serial. The serial source is shared by a receive flag and a transmit flag. Software programs an enable byte and a priority byte. Each priority bit places its source at either the low or the high execution level. Requests are latched as pending flags from one-cycle set pulses. The pending flags are evaluated only when the core signals the end of an instruction.

When a request may be taken, the block offers the handler address on a valid/ready channel. The valid signal and the address stay fixed until the core accepts them with ready. After acceptance the valid signal drops, and the core must not treat the address as meaningful while valid is low. A handshake also clears the hardware-cleared flag of the accepted source and marks its level as in service. Two in-service bits allow a high-level handler to nest inside a low-level one. A return strobe releases the innermost level. A return, or a write to either control byte, blocks acceptance at the next instruction end.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the enable byte and the priority byte are zero, no vector is offered, no pending flag is set and neither in-service bit is set.
- R2: A pending source is offered only when its own enable bit (bit n for source n) and the global bit 7 of the enable byte are both set. Otherwise its flag stays pending.
- R3: Among eligible requests of the same level, the source earliest in the order external 0 (n=0), timer 0 (1), external 1 (2), timer 1 (3), serial (4) wins.
- R4: Priority bit n set to 1 puts source n at the high level. An eligible high-level request wins over any low-level one, regardless of polling order.
- R5: The offered address is 8*n+3 for source n: 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R6: Once vec_valid rises, it and vec_addr stay unchanged until a cycle with vec_ready high. In that cycle the offer is consumed, and vec_valid is low in the following cycle.
- R7: With no level in service, any eligible request is taken. With only the low level in service, only high-level requests are taken. With the high level in service, nothing is taken. in_svc bit 0 is the low level and bit 1 is the high level.
- R8: On acceptance, the pending flag of sources 0 to 3 clears. The serial pending flag (pend bit 4) is the OR of the receive and transmit flags. These two flags are cleared only by their own clear pulses (ser_clr bit 0 for receive, bit 1 for transmit).
- R9: A pending flag persists while it is blocked by an active handler. It is offered once the handler returns.
- R10: A return strobe clears the high in-service bit if that bit is set, and clears the low bit otherwise.
- R11: After a return strobe or a write to either control byte, the next instruction end makes no decision. The one after that can.
- R12: A new offer appears only in the cycle after an instruction-end pulse.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | One-cycle pulse at each instruction boundary |
| reti | input | 1 | One-cycle return-from-handler strobe |
| en_wr | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte: bit 7 global, bits 4..0 per source |
| pri_wr | input | 1 | Priority byte write strobe |
| pri_wdata | input | 8 | Priority byte: bits 4..0 per source, 1 = high |
| hw_set | input | 4 | Set pulses for sources 0..3 |
| ser_set | input | 2 | Serial set pulses: bit 0 receive, bit 1 transmit |
| ser_clr | input | 2 | Serial clear pulses: bit 0 receive, bit 1 transmit |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | Core accepts the offered vector |
| vec_addr | output | 16 | Handler address of the offer |
| pend | output | 5 | Pending flags, bit n = source n |
| in_svc | output | 2 | In-service bits: bit 0 low, bit 1 high |

## Verification
The tests apply three kinds of pending sets. In the first, all five sources are pending at one level. The offers must then come out in polling order and nowhere else. In the second, a later-polled source at the high level competes with an earlier low one. This separates the level comparison from the polling order. The third pattern opens handlers in layers (low, then high, then further requests) and returns in steps. It shows whether blocked requests survive, whether the return releases the right level, and whether the strobes that block one instruction end are honoured. The enable tests separate the per-source gate from the global gate.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  localparam int NSRC = 5;
  localparam int IDXW = $clog2(NSRC);
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
endpackage

// File: rtl/irqn_pending.sv
module irqn_pending
  import irqn_pkg::*;
#(
  parameter int NHW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NHW-1:0]       hw_set,
  input  logic [1:0]           ser_set,
  input  logic [1:0]           ser_clr,
  input  logic                 clr_en,
  input  logic [IDXW-1:0]      clr_idx,
  output logic [NHW:0]         pend
);
  // hardware-cleared sources: a set pulse wins over a same-cycle clear
  for (genvar g = 0; g < NHW; g++) begin : g_hw
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= 1'b0;
      else if (hw_set[g])                           q <= 1'b1;
      else if (clr_en && clr_idx == IDXW'(g))       q <= 1'b0;
    end
    assign pend[g] = q;
  end

  // shared serial source: two flags, cleared only by their own pulses
  logic [1:0] ser_q;
  for (genvar s = 0; s < 2; s++) begin : g_ser
    always_ff @(posedge clk) begin
      if (!rst_n)          ser_q[s] <= 1'b0;
      else if (ser_set[s]) ser_q[s] <= 1'b1;
      else if (ser_clr[s]) ser_q[s] <= 1'b0;
    end
  end
  assign pend[NHW] = |ser_q;

  AST_SER_NOT_HWCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend[NHW] && !(|ser_clr) |=> pend[NHW]);  // R8
endmodule

// File: rtl/irqn_pick.sv
module irqn_pick
  import irqn_pkg::*;
(
  input  logic [NSRC-1:0] cand,
  input  logic [NSRC-1:0] pri,
  input  logic            allow_hi,
  input  logic            allow_lo,
  output logic            win_vld,
  output logic [IDXW-1:0] win_idx,
  output lvl_e            win_lvl,
  output logic [NSRC-1:0] grant
);
  logic [NSRC-1:0] hi_req, lo_req;
  assign hi_req = cand & pri;
  assign lo_req = cand & ~pri;

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = LVL_LO;
    // walk from last to first so the earliest in polling order is kept
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (allow_lo && lo_req[i]) begin
        win_vld = 1'b1;
        win_idx = IDXW'(i);
      end
    end
    // a high-level winner overrides any low-level one
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (allow_hi && hi_req[i]) begin
        win_vld = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = LVL_HI;
      end
    end
    grant = win_vld ? (NSRC'(1) << win_idx) : '0;
  end
endmodule

// File: rtl/irqn_nest.sv
module irqn_nest
  import irqn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  lvl_e       take_lvl,
  input  logic       reti,
  output logic [1:0] isv
);
  logic [1:0] isv_n;
  always_comb begin
    isv_n = isv;
    if (reti) begin
      if (isv[1]) isv_n[1] = 1'b0;
      else        isv_n[0] = 1'b0;
    end
    if (take) begin
      if (take_lvl == LVL_HI) isv_n[1] = 1'b1;
      else                    isv_n[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isv <= '0;
    else        isv <= isv_n;
  end

  AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !take && isv == 2'b11 |=> isv == 2'b01);  // R10
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irqn_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 8,
  parameter int VEC_STEP = 8,
  parameter int VEC_BASE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              reti,
  input  logic              en_wr,
  input  logic [REG_W-1:0]  en_wdata,
  input  logic              pri_wr,
  input  logic [REG_W-1:0]  pri_wdata,
  input  logic [NSRC-2:0]   hw_set,
  input  logic [1:0]        ser_set,
  input  logic [1:0]        ser_clr,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [NSRC-1:0]   pend,
  output logic [1:0]        in_svc
);
  localparam int GBIT = REG_W - 1;

  logic [NSRC-1:0] en_src_q, pri_q;
  logic            en_all_q;
  logic            block_q;
  logic [IDXW-1:0] vec_idx;
  lvl_e            vec_lvl;

  logic unused_wbits;
  assign unused_wbits = ^{en_wdata[GBIT-1:NSRC], pri_wdata[REG_W-1:NSRC]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_src_q <= '0;
      en_all_q <= 1'b0;
      pri_q    <= '0;
    end else begin
      if (en_wr) begin
        en_src_q <= en_wdata[NSRC-1:0];
        en_all_q <= en_wdata[GBIT];
      end
      if (pri_wr) pri_q <= pri_wdata[NSRC-1:0];
    end
  end

  logic strobe, take, decide;
  assign strobe = reti | en_wr | pri_wr;
  assign take   = vec_valid & vec_ready;
  assign decide = insn_end & ~block_q & ~strobe & ~vec_valid;

  // one boundary of hold-off after a return or control write
  always_ff @(posedge clk) begin
    if (!rst_n) block_q <= 1'b0;
    else        block_q <= strobe | (block_q & ~insn_end);
  end

  irqn_pending #(.NHW(NSRC - 1)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .ser_set(ser_set),
    .ser_clr(ser_clr), .clr_en(take), .clr_idx(vec_idx), .pend(pend)
  );

  irqn_nest u_nest (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(vec_lvl),
    .reti(reti), .isv(in_svc)
  );

  logic [NSRC-1:0] cand, grant;
  logic            win_vld;
  logic [IDXW-1:0] win_idx;
  lvl_e            win_lvl;
  assign cand = pend & en_src_q & {NSRC{en_all_q}};

  irqn_pick u_pick (
    .cand(cand), .pri(pri_q), .allow_hi(~in_svc[1]), .allow_lo(in_svc == 2'b00),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      vec_lvl   <= LVL_LO;
    end else if (take) begin
      vec_valid <= 1'b0;
    end else if (decide && win_vld) begin
      vec_valid <= 1'b1;
      vec_idx   <= win_idx;
      vec_lvl   <= win_lvl;
    end
  end

  assign vec_addr = ADDR_W'(32'(vec_idx) * VEC_STEP + VEC_BASE);

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr));  // R6
  AST_OFFER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid);  // R6
  AST_ADDR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (32'(vec_addr) % VEC_STEP) == VEC_BASE);  // R5
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !vec_valid |=> !vec_valid);  // R11
  AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !in_svc[1]);  // R7
  AST_SVC_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_svc != 2'b00);  // R7
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R3
  AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(insn_end));  // R12
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rst_n, insn_end, reti, en_wr, pri_wr, vec_ready;
  logic [7:0]  en_wdata, pri_wdata;
  logic [3:0]  hw_set;
  logic [1:0]  ser_set, ser_clr, in_svc;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic [4:0]  pend;

  irq_nest_ctrl dut (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .reti(reti),
    .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
    .hw_set(hw_set), .ser_set(ser_set), .ser_clr(ser_clr),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .pend(pend), .in_svc(in_svc)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; insn_end = 0; reti = 0; en_wr = 0; pri_wr = 0; vec_ready = 0;
    en_wdata = 0; pri_wdata = 0; hw_set = 0; ser_set = 0; ser_clr = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic boundary();
    insn_end = 1'b1; tick(); insn_end = 1'b0;
  endtask
  task automatic accept();
    vec_ready = 1'b1; tick(); vec_ready = 1'b0;
  endtask
  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask
  task automatic wr_en(logic [7:0] v);
    en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0;
  endtask
  task automatic wr_pri(logic [7:0] v);
    pri_wdata = v; pri_wr = 1'b1; tick(); pri_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", vec_valid, 0);
    chk("R1 pend", pend, 0);
    chk("R1 in_svc", in_svc, 0);
    hw_set = 4'h1; tick(); hw_set = 0;
    boundary();
    chk("R1 enables zero after reset", vec_valid, 0);
  endtask

  task automatic t_gate();
    do_reset();
    hw_set = 4'h1; tick(); hw_set = 0;
    wr_en(8'h01); boundary(); boundary();
    chk("R2 no global bit", vec_valid, 0);
    chk("R2 flag kept", pend[0], 1);
    wr_en(8'h80); boundary(); boundary();
    chk("R2 no source bit", vec_valid, 0);
    wr_en(8'h81);
    tick(); tick();
    chk("R12 no offer without boundary", vec_valid, 0);
    boundary();
    chk("R11 boundary after write blocked", vec_valid, 0);
    boundary();
    chk("R2 offer when both set", vec_valid, 1);
    chk("R5 ext0 addr", vec_addr, 16'h0003);
    accept();
    chk("R8 ext0 cleared", pend[0], 0);
    chk("R7 low in service", in_svc, 2'b01);
    ret();
    chk("R10 low released", in_svc, 2'b00);
  endtask

  task automatic t_poll();
    do_reset();
    wr_en(8'h9F); boundary();
    hw_set = 4'hF; ser_set = 2'b01; tick(); hw_set = 0; ser_set = 0;
    chk("R9 all pending", pend, 5'h1F);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin ret(); boundary(); end
      boundary();
      chk("R3 polling order offer", vec_valid, 1);
      chk("R3 R5 polling order addr", vec_addr, 32'(k * 8 + 3));
      if (k == 0) begin
        tick(); tick(); tick();
        chk("R6 held valid", vec_valid, 1);
        chk("R6 held addr", vec_addr, 16'h0003);
      end
      accept();
      chk("R6 dropped after ready", vec_valid, 0);
      if (k < 4) chk("R8 hw clear", pend[k], 0);
      else       chk("R8 serial not hw cleared", pend[4], 1);
      if (k == 0) begin
        boundary();
        chk("R7 low not under low", vec_valid, 0);
      end
    end
    ser_clr = 2'b01; tick(); ser_clr = 0;
    chk("R8 serial cleared by own pulse", pend[4], 0);
  endtask

  task automatic t_level();
    do_reset();
    wr_en(8'h9F); wr_pri(8'h10); boundary();
    hw_set = 4'h2; ser_set = 2'b10; tick(); hw_set = 0; ser_set = 0;
    boundary();
    chk("R4 high serial over low timer0", vec_addr, 16'h0023);
    accept();
    chk("R7 high in service", in_svc, 2'b10);
    hw_set = 4'h1; tick(); hw_set = 0;
    boundary();
    chk("R7 nothing under high", vec_valid, 0);
    ret();
    chk("R10 high released", in_svc, 2'b00);
    ser_clr = 2'b10; tick(); ser_clr = 0;
    boundary(); boundary();
    chk("R3 low ext0 before timer0", vec_addr, 16'h0003);
    chk("R3 offer valid", vec_valid, 1);
  endtask

  task automatic t_nest();
    do_reset();
    wr_en(8'h9F); wr_pri(8'h02); boundary();
    hw_set = 4'h4; tick(); hw_set = 0;
    boundary();
    chk("R7 ext1 taken when idle", vec_addr, 16'h0013);
    accept();
    hw_set = 4'h1; tick(); hw_set = 0;
    boundary();
    chk("R7 low ext0 blocked", vec_valid, 0);
    hw_set = 4'h2; tick(); hw_set = 0;
    boundary();
    chk("R7 high timer0 preempts", vec_addr, 16'h000B);
    accept();
    chk("R7 both levels", in_svc, 2'b11);
    ret();
    chk("R10 high bit first", in_svc, 2'b01);
    boundary(); boundary();
    chk("R9 ext0 still blocked", vec_valid, 0);
    chk("R9 ext0 still pending", pend[0], 1);
    ret();
    chk("R10 low bit next", in_svc, 2'b00);
    boundary();
    chk("R11 boundary after return blocked", vec_valid, 0);
    boundary();
    chk("R9 latched ext0 served", vec_addr, 16'h0003);
    chk("R9 offer valid", vec_valid, 1);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_poll();
    t_level();
    t_nest();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule